// File: doc/BRIEF.md
# Banked Memory Map Dispatcher

This block sits between a CPU bus front end and the memory and device back ends of a socket-replacement board. For every bus transaction it takes the 16-bit address, the memory-or-I/O qualifier and the direction, and decides what happens next. The access can be handed to the real host bus, served from a location in a 4 MB banked backing RAM, dropped, or turned into a request to a numbered virtual-device handler. The memory space is cut into 128 blocks of 512 bytes. Each block carries its own configuration entry with a type, a bank, a block-within-bank, and a wait-state count. A shared 512-entry redirect table lets one block type steer each of its bytes to a different destination. A separate 256-entry table classifies I/O ports.

A configuration port writes the three tables one entry at a time. The lookup is combinational from the request, and the response is registered, so a result appears on the clock edge after the request. The backing RAM controller and the handler code use the response and are outside this block.

Top module: `memmap_dispatch`

## Requirements
- R1: `rsp_valid` is high for exactly the one cycle after each cycle in which `req_valid` is high, and low otherwise. The other response outputs keep their last value while no request is made.
- R2: After reset every table entry is zero, so any request resolves as a host pass-through with zero waits. All response outputs reset to zero.
- R3: A block entry packs `type[18:16]`, `bank[15:10]`, `blk[9:3]` and `wait[2:0]`. The block is selected by address bits 15:9. For type RAM (code 3), the action is backing memory (action code 1), `rsp_phys = {bank, blk, addr[8:0]}` and `rsp_ro` is 0. For every action other than 1, `rsp_phys` is zero.
- R4: A read from a ROM block (type code 4) gives action 1, with the backing address as for RAM and `rsp_ro` = 1. A write to a ROM block gives action drop (code 3) with `rsp_ro` = 1.
- R5: An access to a VRAM block (type code 5) gives action 1 and the backing address. `rsp_mirror` is 1 only when the access is a write.
- R6: Types PHYSICAL (0) and PHYSICAL_HW (2) give action host (code 0) with `rsp_wait` equal to the entry's wait field. PHYSICAL_VRAM (1) adds `VRAM_EXTRA` (default 2) to the wait field, saturating at the maximum of `rsp_wait`.
- R7: A FUNC block (type code 6) gives action handler (code 2), with `rsp_handler` equal to the entry's `blk` field.
- R8: A PTR block (type code 7) replaces its entry with the redirect-table entry indexed by address bits 8:0, and then resolves that entry by R3–R7. If the redirect entry is itself PTR, the access resolves as host pass-through with that entry's wait field. Only one level of redirection is followed.
- R9: When `req_io` is 1, only the port table is used, indexed by address bits 7:0. Entry bit 7 set gives action 2 with `rsp_handler` = entry bits 6:0. Bit 7 clear gives action 0. In both cases wait is 0, the backing address is 0, and both flags are 0, whatever the memory tables hold.
- R10: `cfg_sel` selects the block table (0, index `cfg_idx[6:0]`), the redirect table (1, `cfg_idx[8:0]`) or the port table (2, `cfg_idx[7:0]`, data bits 7:0). A write in the same cycle as a request does not affect that request and applies from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration entry write strobe |
| cfg_sel | input | 2 | Table select: 0 block, 1 redirect, 2 port |
| cfg_idx | input | 9 | Entry index within the selected table |
| cfg_data | input | 19 | Entry value |
| req_valid | input | 1 | A bus transaction is presented this cycle |
| req_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Transaction address |
| rsp_valid | output | 1 | Response is valid this cycle |
| rsp_action | output | 2 | 0 host, 1 backing memory, 2 handler, 3 drop |
| rsp_phys | output | 22 | Backing memory byte address |
| rsp_ro | output | 1 | Target is read-only |
| rsp_mirror | output | 1 | Also pass the write to the host |
| rsp_wait | output | 4 | Wait states to insert |
| rsp_handler | output | 7 | Virtual-device handler ID |

## Verification
The bound checker checks on every cycle the properties that do not depend on table contents:
- the one-cycle response pulse;
- that a read never yields a drop or a mirror;
- that a drop always carries the read-only flag;
- that the backing address is zero for non-memory actions;
- that I/O cycles only give host or handler results with clear flags.

Three kinds of behaviour depend on what was written into the tables, so only the bench's scenarios can show them: the exact backing address arithmetic, the per-type dispatch including the PHYSICAL_VRAM wait addition, and the redirect resolution. The same holds for the rule that a same-cycle configuration write is seen only by the next request.

// File: rtl/memmap_dispatch.sv
module memmap_dispatch #(
  parameter int BANK_W     = 6,
  parameter int WAIT_W     = 3,
  parameter int OWAIT_W    = 4,
  parameter int VRAM_EXTRA = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [8:0]                 cfg_idx,
  input  logic [3+BANK_W+7+WAIT_W-1:0] cfg_data,
  input  logic                       req_valid,
  input  logic                       req_io,
  input  logic                       req_write,
  input  logic [15:0]                req_addr,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_action,
  output logic [BANK_W+16-1:0]       rsp_phys,
  output logic                       rsp_ro,
  output logic                       rsp_mirror,
  output logic [OWAIT_W-1:0]         rsp_wait,
  output logic [6:0]                 rsp_handler
);
  localparam int OFS_W  = 9;
  localparam int BLK_W  = 16 - OFS_W;
  localparam int NBLK   = 1 << BLK_W;
  localparam int NRED   = 1 << OFS_W;
  localparam int NPORT  = 256;
  localparam int TYPE_W = 3;
  localparam int ENT_W  = TYPE_W + BANK_W + BLK_W + WAIT_W;
  localparam int PHYS_W = BANK_W + 16;
  localparam logic [OWAIT_W:0] WMAX = (OWAIT_W+1)'((1 << OWAIT_W) - 1);

  localparam logic [2:0] T_PHYS = 3'd0, T_PVRAM = 3'd1, T_PHW = 3'd2, T_RAM = 3'd3,
                         T_ROM = 3'd4, T_VRAM = 3'd5, T_FUNC = 3'd6, T_PTR = 3'd7;
  localparam logic [1:0] A_HOST = 2'd0, A_MEM = 2'd1, A_FUNC = 2'd2, A_DROP = 2'd3;

  logic [ENT_W-1:0] blk_tab  [NBLK];
  logic [ENT_W-1:0] red_tab  [NRED];
  logic [BLK_W:0]   port_tab [NPORT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++)  blk_tab[i]  <= '0;
      for (int i = 0; i < NRED; i++)  red_tab[i]  <= '0;
      for (int i = 0; i < NPORT; i++) port_tab[i] <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: blk_tab[cfg_idx[BLK_W-1:0]] <= cfg_data;
        2'd1: red_tab[cfg_idx]            <= cfg_data;
        2'd2: port_tab[cfg_idx[7:0]]      <= cfg_data[BLK_W:0];
        default: ;
      endcase
    end
  end

  wire [ENT_W-1:0] ent_b = blk_tab[req_addr[15:OFS_W]];
  wire [ENT_W-1:0] ent_r = red_tab[req_addr[OFS_W-1:0]];
  wire [ENT_W-1:0] ent   = (ent_b[ENT_W-1 -: TYPE_W] == T_PTR) ? ent_r : ent_b;
  wire [BLK_W:0]   pent  = port_tab[req_addr[7:0]];

  wire [TYPE_W-1:0] e_type = ent[ENT_W-1 -: TYPE_W];
  wire [BANK_W-1:0] e_bank = ent[BLK_W+WAIT_W +: BANK_W];
  wire [BLK_W-1:0]  e_blk  = ent[WAIT_W +: BLK_W];
  wire [WAIT_W-1:0] e_wait = ent[WAIT_W-1:0];

  wire [OWAIT_W:0] w_base = (OWAIT_W+1)'(e_wait);
  wire [OWAIT_W:0] w_sum  = w_base + (OWAIT_W+1)'(VRAM_EXTRA);
  wire [OWAIT_W-1:0] w_vram = (w_sum > WMAX) ? WMAX[OWAIT_W-1:0] : w_sum[OWAIT_W-1:0];
  wire [PHYS_W-1:0]  phys   = {e_bank, e_blk, req_addr[OFS_W-1:0]};

  logic [1:0]         n_act;
  logic [PHYS_W-1:0]  n_phys;
  logic               n_ro, n_mir;
  logic [OWAIT_W-1:0] n_wait;
  logic [BLK_W-1:0]   n_hid;

  always_comb begin
    n_act  = A_HOST;
    n_phys = '0;
    n_ro   = 1'b0;
    n_mir  = 1'b0;
    n_wait = '0;
    n_hid  = '0;
    if (req_io) begin
      n_act = pent[BLK_W] ? A_FUNC : A_HOST;
      n_hid = pent[BLK_W] ? pent[BLK_W-1:0] : '0;
    end else begin
      case (e_type)
        T_PVRAM: n_wait = w_vram;
        T_RAM:   begin n_act = A_MEM; n_phys = phys; n_wait = w_base[OWAIT_W-1:0]; end
        T_ROM:   begin
                   n_ro   = 1'b1;
                   n_act  = req_write ? A_DROP : A_MEM;
                   n_phys = req_write ? '0 : phys;
                   n_wait = w_base[OWAIT_W-1:0];
                 end
        T_VRAM:  begin
                   n_act = A_MEM; n_phys = phys; n_mir = req_write;
                   n_wait = w_base[OWAIT_W-1:0];
                 end
        T_FUNC:  begin n_act = A_FUNC; n_hid = e_blk; n_wait = w_base[OWAIT_W-1:0]; end
        default: n_wait = w_base[OWAIT_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_action  <= A_HOST;
      rsp_phys    <= '0;
      rsp_ro      <= 1'b0;
      rsp_mirror  <= 1'b0;
      rsp_wait    <= '0;
      rsp_handler <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_action  <= n_act;
        rsp_phys    <= n_phys;
        rsp_ro      <= n_ro;
        rsp_mirror  <= n_mir;
        rsp_wait    <= n_wait;
        rsp_handler <= n_hid;
      end
    end
  end
endmodule

// File: rtl/memmap_dispatch_chk.sv
module memmap_dispatch_chk #(
  parameter int PHYS_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_io,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [1:0]        rsp_action,
  input logic [PHYS_W-1:0] rsp_phys,
  input logic              rsp_ro,
  input logic              rsp_mirror
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r3_phys_only_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_action != 2'd1) |-> (rsp_phys == '0));
  a_r4_read_never_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (rsp_action != 2'd3));
  a_r4_drop_is_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_action == 2'd3) |-> rsp_ro);
  a_r5_mirror_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !rsp_mirror);
  a_r9_io_result: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_io) |=> ((rsp_action == 2'd0 || rsp_action == 2'd2)
                               && !rsp_ro && !rsp_mirror && rsp_phys == '0));
endmodule

bind memmap_dispatch memmap_dispatch_chk #(.PHYS_W(BANK_W + 16)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_io     (req_io),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_action (rsp_action),
  .rsp_phys   (rsp_phys),
  .rsp_ro     (rsp_ro),
  .rsp_mirror (rsp_mirror)
);

// File: tb/test_memmap_dispatch.sv
`timescale 1ns/1ps
module test_memmap_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [8:0]  cfg_idx = '0;
  logic [18:0] cfg_data = '0;
  logic        req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        rsp_valid, rsp_ro, rsp_mirror;
  logic [1:0]  rsp_action;
  logic [21:0] rsp_phys;
  logic [3:0]  rsp_wait;
  logic [6:0]  rsp_handler;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  memmap_dispatch i_memmap_dispatch (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_io(req_io), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_action(rsp_action),
    .rsp_phys(rsp_phys), .rsp_ro(rsp_ro), .rsp_mirror(rsp_mirror),
    .rsp_wait(rsp_wait), .rsp_handler(rsp_handler)
  );

  // {io, write, addr, action, phys, ro, mirror, wait, handler}
  localparam int NV = 18;
  localparam logic [54:0] VEC [NV] = '{
    {1'b0,1'b0,16'h0003,2'd1,22'h010A03,1'b1,1'b0,4'd0,7'h00},
    {1'b0,1'b1,16'h0003,2'd3,22'h000000,1'b1,1'b0,4'd0,7'h00},
    {1'b0,1'b0,16'h03FF,2'd1,22'h3FFFFF,1'b0,1'b0,4'd1,7'h00},
    {1'b0,1'b1,16'h0200,2'd1,22'h3FFE00,1'b0,1'b0,4'd1,7'h00},
    {1'b0,1'b1,16'h0456,2'd1,22'h020656,1'b0,1'b1,4'd0,7'h00},
    {1'b0,1'b0,16'h0456,2'd1,22'h020656,1'b0,1'b0,4'd0,7'h00},
    {1'b0,1'b0,16'h0700,2'd0,22'h000000,1'b0,1'b0,4'd9,7'h00},
    {1'b0,1'b1,16'h0800,2'd0,22'h000000,1'b0,1'b0,4'd3,7'h00},
    {1'b0,1'b0,16'h0A10,2'd2,22'h000000,1'b0,1'b0,4'd0,7'h55},
    {1'b0,1'b0,16'h0C10,2'd1,22'h030810,1'b0,1'b0,4'd0,7'h00},
    {1'b0,1'b1,16'h0C11,2'd2,22'h000000,1'b0,1'b0,4'd0,7'h09},
    {1'b0,1'b0,16'h0C12,2'd0,22'h000000,1'b0,1'b0,4'd2,7'h00},
    {1'b0,1'b0,16'h0C13,2'd0,22'h000000,1'b0,1'b0,4'd0,7'h00},
    {1'b0,1'b0,16'hFFFF,2'd1,22'h0003FF,1'b0,1'b0,4'd0,7'h00},
    {1'b0,1'b0,16'h1000,2'd0,22'h000000,1'b0,1'b0,4'd0,7'h00},
    {1'b1,1'b0,16'h12E0,2'd2,22'h000000,1'b0,1'b0,4'd0,7'h12},
    {1'b1,1'b1,16'h0010,2'd0,22'h000000,1'b0,1'b0,4'd0,7'h00},
    {1'b1,1'b0,16'h0A05,2'd0,22'h000000,1'b0,1'b0,4'd0,7'h00}
  };

  function automatic string req_of(int i);
    case (i)
      0, 1:       return "R4";
      2, 3, 13:   return "R3";
      4, 5:       return "R5";
      6, 7, 14:   return "R6";
      8:          return "R7";
      9, 10, 11, 12: return "R8";
      default:    return "R9";
    endcase
  endfunction

  function automatic logic [18:0] ent(int t, int b, int k, int w);
    return {3'(t), 6'(b), 7'(k), 3'(w)};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] sel, int idx, logic [18:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 9'(idx); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic request(logic io, logic wr, logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_io = io; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [36:0] resp();
    return {rsp_action, rsp_phys, rsp_ro, rsp_mirror, rsp_wait, rsp_handler};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R2", 64'({rsp_valid, resp()}), 64'd0);
    rst_n = 1'b1;
    request(1'b0, 1'b1, 16'h0000);
    check("R2", 64'({rsp_valid, resp()}), 64'({1'b1, 37'd0}));
    @(negedge clk);
    check("R1", 64'(rsp_valid), 64'd0);

    cfg(2'd0, 0,   ent(4, 1, 5, 0));
    cfg(2'd0, 1,   ent(3, 63, 127, 1));
    cfg(2'd0, 2,   ent(5, 2, 3, 0));
    cfg(2'd0, 3,   ent(1, 0, 0, 7));
    cfg(2'd0, 4,   ent(2, 0, 0, 3));
    cfg(2'd0, 5,   ent(6, 0, 7'h55, 0));
    cfg(2'd0, 6,   ent(7, 0, 0, 0));
    cfg(2'd0, 127, ent(3, 0, 1, 0));
    cfg(2'd1, 16,  ent(3, 3, 4, 0));
    cfg(2'd1, 17,  ent(6, 0, 9, 0));
    cfg(2'd1, 18,  ent(7, 0, 0, 2));
    cfg(2'd2, 8'hE0, 19'h00092);
    cfg(2'd2, 8'h10, 19'h00000);

    for (int i = 0; i < NV; i++) begin
      request(VEC[i][54], VEC[i][53], VEC[i][52:37]);
      check("R1", 64'(rsp_valid), 64'd1);
      check(req_of(i), 64'(resp()), 64'(VEC[i][36:0]));
    end

    // R1: outputs hold when no request is made
    @(negedge clk);
    check("R1", 64'({rsp_valid, resp()}), 64'({1'b0, VEC[NV-1][36:0]}));

    // R10: same-cycle configuration write affects only the next request
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_idx = 9'd8; cfg_data = ent(3, 5, 6, 0);
    req_valid = 1'b1; req_io = 1'b0; req_write = 1'b0; req_addr = 16'h1004;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R10", 64'(resp()), 64'd0);
    request(1'b0, 1'b0, 16'h1004);
    check("R10", 64'({rsp_action, rsp_phys}), 64'({2'd1, 22'h050C04}));

    // R10: select 3 is not a table; block 9 stays pass-through
    cfg(2'd3, 9, ent(3, 1, 1, 0));
    request(1'b0, 1'b0, 16'h1200);
    check("R10", 64'(resp()), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule